// File: doc/BRIEF.md
# Majority-in-Memory Sequencing Controller

This block wraps a one-bit-wide data array together with a word-wide instruction store. It runs programs built from a single operation: the destination bit is overwritten with the three-input majority of operand A, the inverse of operand B, and the destination's own previous value. Each operand is either a constant or a bit read from the data array. Because the destination's old value is one of the majority inputs, the computation happens as part of the write.

A mode input picks between two uses. With the mode low, the controller stays idle and both stores act as plain RAM through an external address, write-data, write-enable and region-select port, with a registered read. With the mode high, the controller runs the program serially from instruction address 0. For each instruction it fetches the word, reads A, reads B, reads the destination, writes the result and steps the program counter. A destination address of all ones ends the program.

Top module: `maj_seq_ctrl`

## Requirements
- R1: With mode_i low, ext_we_i high and ext_sel_i low, bit ext_wdata_i[0] is written to data bit ext_addr_i. With ext_sel_i low, ext_rdata_o shows that data bit in bit 0 with all upper bits zero, one clock after the address is presented. The read returns the value held before any write made on the same edge.
- R2: With mode_i low and ext_sel_i high, the same port writes and reads full instruction words at ext_addr_i, with the same one-clock read latency.
- R3: For AW=4 the instruction word has these fields: [15] A-constant flag, [14] A constant value, [13:10] A address, [9] B-constant flag, [8] B constant value, [7:4] B address, [3:0] destination address.
- R4: An executed instruction replaces the destination bit with MAJ(A, NOT B, Z_old), where MAJ(x,y,z) = xy | xz | yz.
- R5: When an operand's constant flag is 1, that operand equals its constant-value bit, and its address field has no effect.
- R6: Execution starts at instruction address 0 on the first clock edge with mode_i high. Each instruction takes six clocks. Its destination write lands on the fifth edge after its fetch state is entered, and instructions run strictly one after another.
- R7: An instruction whose destination address is all ones writes nothing. It raises done_o two edges after its fetch state is entered, and done_o then stays high while mode_i stays high.
- R8: While mode_i is high, external writes to either region are ignored and ext_rdata_o keeps its value.
- R9: Driving mode_i low at any point returns the controller to idle on the next edge, suppresses any pending write and clears done_o. The next run restarts at instruction address 0.
- R10: After reset, done_o is 0, ext_rdata_o is 0 and the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 1 runs the program, 0 gives plain RAM access |
| ext_sel_i | input | 1 | RAM-mode region select: 0 data bits, 1 instruction words |
| ext_addr_i | input | AW | RAM-mode address |
| ext_we_i | input | 1 | RAM-mode write enable |
| ext_wdata_i | input | IW | RAM-mode write data; bit 0 only for the data region |
| ext_rdata_o | output | IW | Registered RAM-mode read data |
| done_o | output | 1 | High once a halt instruction has been reached |

## Verification
A wrong sequencer state or operand register in this block does not show at the ports while the program runs. It is seen either when done_o rises in the wrong cycle or when the data region is read back after the mode drops. For that reason the bench tracks done_o on every clock against a cycle-counting model, and it reads back every data bit after each run, so that a wrong majority, a swapped operand or an inversion on the wrong input shows up one read latency after the sweep reaches the affected bit. Runs aborted partway through show a write that should have been suppressed in the same sweep.

// File: rtl/maj_seq_pkg.sv
package maj_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_RD_A, ST_RD_B, ST_RD_Z, ST_WR_Z, ST_NEXT, ST_HALT
  } seq_state_e;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/maj_seq_ram.sv
module maj_seq_ram #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);
  localparam int Depth = 1 << AW;

  logic [DW-1:0] mem_q [Depth];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/maj_seq_fsm.sv
module maj_seq_fsm
  import maj_seq_pkg::*;
#(
  parameter int AW = 4,
  parameter int IW = 3 * AW + 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  output logic [AW-1:0] pc_o,
  input  logic [IW-1:0] instr_i,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_bit_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          wr_bit_o,
  output logic          done_o
);
  // field positions, destination in the low bits
  localparam int ZLo  = 0;
  localparam int BAdr = AW;
  localparam int BVal = 2 * AW;
  localparam int BCst = 2 * AW + 1;
  localparam int AAdr = 2 * AW + 2;
  localparam int AVal = 3 * AW + 2;
  localparam int ACst = 3 * AW + 3;

  seq_state_e    state_q, state_d;
  logic [AW-1:0] pc_q;
  logic [IW-1:0] ir_q;
  logic          a_q, b_q, z_q;

  logic [AW-1:0] a_adr, b_adr, z_adr;
  logic          halt;

  assign a_adr = ir_q[AAdr +: AW];
  assign b_adr = ir_q[BAdr +: AW];
  assign z_adr = ir_q[ZLo +: AW];
  assign halt  = &z_adr;

  always_comb begin
    state_d = state_q;
    if (!mode_i) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:  state_d = ST_FETCH;
        ST_FETCH: state_d = ST_RD_A;
        ST_RD_A:  state_d = halt ? ST_HALT : ST_RD_B;
        ST_RD_B:  state_d = ST_RD_Z;
        ST_RD_Z:  state_d = ST_WR_Z;
        ST_WR_Z:  state_d = ST_NEXT;
        ST_NEXT:  state_d = ST_FETCH;
        ST_HALT:  state_d = ST_HALT;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      ir_q    <= '0;
      a_q     <= 1'b0;
      b_q     <= 1'b0;
      z_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      case (state_q)
        ST_IDLE:  pc_q <= '0;
        ST_FETCH: ir_q <= instr_i;
        ST_RD_A:  a_q  <= ir_q[ACst] ? ir_q[AVal] : rd_bit_i;
        ST_RD_B:  b_q  <= ir_q[BCst] ? ir_q[BVal] : rd_bit_i;
        ST_RD_Z:  z_q  <= rd_bit_i;
        ST_NEXT:  pc_q <= pc_q + 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_RD_A: rd_addr_o = a_adr;
      ST_RD_B: rd_addr_o = b_adr;
      default: rd_addr_o = z_adr;
    endcase
  end

  assign pc_o      = pc_q;
  assign wr_en_o   = (state_q == ST_WR_Z);
  assign wr_addr_o = z_adr;
  assign wr_bit_o  = maj3(a_q, ~b_q, z_q);
  assign done_o    = (state_q == ST_HALT);

  // R7
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_i) |=> done_o);
  // R9
  mode_low_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |=> (!done_o && !wr_en_o));
  // R6
  serial_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);
endmodule

// File: rtl/maj_seq_ctrl.sv
module maj_seq_ctrl #(
  parameter int AW = 4,
  parameter int IW = 3 * AW + 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          ext_sel_i,
  input  logic [AW-1:0] ext_addr_i,
  input  logic          ext_we_i,
  input  logic [IW-1:0] ext_wdata_i,
  output logic [IW-1:0] ext_rdata_o,
  output logic          done_o
);
  logic [AW-1:0] pc;
  logic [IW-1:0] instr, im_ext;
  logic [AW-1:0] fsm_rd_addr, fsm_wr_addr;
  logic          fsm_rd_bit, fsm_we, fsm_wr_bit, dm_ext;
  logic          im_we, dm_we, dm_wbit;
  logic [AW-1:0] dm_waddr;
  logic [IW-1:0] rdata_q;

  assign im_we    = !mode_i && ext_we_i && ext_sel_i;
  assign dm_we    = mode_i ? fsm_we : (ext_we_i && !ext_sel_i);
  assign dm_waddr = mode_i ? fsm_wr_addr : ext_addr_i;
  assign dm_wbit  = mode_i ? fsm_wr_bit : ext_wdata_i[0];

  maj_seq_ram #(.AW(AW), .DW(IW)) u_imem (
    .clk_i     (clk_i),
    .we_i      (im_we),
    .waddr_i   (ext_addr_i),
    .wdata_i   (ext_wdata_i),
    .raddr_a_i (pc),
    .rdata_a_o (instr),
    .raddr_b_i (ext_addr_i),
    .rdata_b_o (im_ext)
  );

  maj_seq_ram #(.AW(AW), .DW(1)) u_dmem (
    .clk_i     (clk_i),
    .we_i      (dm_we),
    .waddr_i   (dm_waddr),
    .wdata_i   (dm_wbit),
    .raddr_a_i (fsm_rd_addr),
    .rdata_a_o (fsm_rd_bit),
    .raddr_b_i (ext_addr_i),
    .rdata_b_o (dm_ext)
  );

  maj_seq_fsm #(.AW(AW), .IW(IW)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .pc_o      (pc),
    .instr_i   (instr),
    .rd_addr_o (fsm_rd_addr),
    .rd_bit_i  (fsm_rd_bit),
    .wr_en_o   (fsm_we),
    .wr_addr_o (fsm_wr_addr),
    .wr_bit_o  (fsm_wr_bit),
    .done_o    (done_o)
  );

  // read register only follows the port in RAM mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (!mode_i) rdata_q <= ext_sel_i ? im_ext : {{(IW-1){1'b0}}, dm_ext};
  end

  assign ext_rdata_o = rdata_q;

  // R8
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |=> $stable(ext_rdata_o));
  // R7
  halt_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && fsm_we) |-> !(&fsm_wr_addr));
  // R8
  ext_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |-> !im_we);
endmodule

// File: tb/maj_seq_ctrl_test.sv
module maj_seq_ctrl_test;
  localparam int AW = 4;
  localparam int IW = 3 * AW + 4;
  localparam int N  = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mode_i = 1'b0;
  logic          ext_sel_i = 1'b0;
  logic [AW-1:0] ext_addr_i = '0;
  logic          ext_we_i = 1'b0;
  logic [IW-1:0] ext_wdata_i = '0;
  logic [IW-1:0] ext_rdata_o;
  logic          done_o;

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    chk_rd = 1'b0;
  string req_tag = "R10";

  // behavioural model state
  logic [IW-1:0] m_im [N];
  logic          m_dm [N];
  logic [IW-1:0] m_rdata;
  bit            m_act, m_done;
  int            m_cnt, m_pc;

  maj_seq_ctrl #(.AW(AW), .IW(IW)) uut (
    .clk_i, .rst_ni, .mode_i, .ext_sel_i, .ext_addr_i,
    .ext_we_i, .ext_wdata_i, .ext_rdata_o, .done_o
  );

  always #10 clk_i = ~clk_i;

  function automatic logic [IW-1:0] enc(input bit ac, input bit av, input int aa,
                                        input bit bc, input bit bv, input int ba,
                                        input int z);
    // R3 field layout
    return {ac, av, 4'(aa), bc, bv, 4'(ba), 4'(z)};
  endfunction

  function automatic logic opnd(input bit c, input bit v, input logic [AW-1:0] a);
    return c ? v : m_dm[a];  // R5
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_rdata = '0; m_act = 0; m_done = 0; m_cnt = 0; m_pc = 0;
    end else if (!mode_i) begin
      m_act = 0; m_done = 0;  // R9
      m_rdata = ext_sel_i ? m_im[ext_addr_i] : {{(IW-1){1'b0}}, m_dm[ext_addr_i]};
      if (ext_we_i) begin
        if (ext_sel_i) m_im[ext_addr_i] = ext_wdata_i;
        else m_dm[ext_addr_i] = ext_wdata_i[0];
      end
    end else if (!m_act) begin
      m_act = 1; m_cnt = 0; m_pc = 0;  // R6
    end else if (!m_done) begin
      logic [IW-1:0] w;
      logic a, b;
      w = m_im[m_pc];
      if (m_cnt == 1 && w[3:0] == 4'hF) m_done = 1;  // R7
      else if (m_cnt == 4) begin
        a = opnd(w[15], w[14], w[13:10]);
        b = opnd(w[9], w[8], w[7:4]);
        m_dm[w[3:0]] = (a & ~b) | (a & m_dm[w[3:0]]) | (~b & m_dm[w[3:0]]);  // R4
      end
      if (!m_done) begin
        if (m_cnt == 5) begin m_cnt = 0; m_pc = (m_pc + 1) % N; end
        else m_cnt++;
      end
    end
  end

  always @(negedge clk_i) begin
    cyc++;
    n_chk++;
    if (done_o !== m_done) begin
      n_bad++;
      $display("FAIL %s done_o actual %b expected %b at cycle %0d", req_tag, done_o, m_done, cyc);
    end
    if (chk_rd) begin
      n_chk++;
      if (ext_rdata_o !== m_rdata) begin
        n_bad++;
        $display("FAIL %s ext_rdata_o actual %h expected %h at cycle %0d",
                 req_tag, ext_rdata_o, m_rdata, cyc);
      end
    end
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog actual %0d cycles expected fewer", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic step(input bit m, input bit s, input int a, input bit we, input logic [IW-1:0] d);
    @(negedge clk_i);
    #2;
    mode_i = m; ext_sel_i = s; ext_addr_i = AW'(a); ext_we_i = we; ext_wdata_i = d;
  endtask

  task automatic sweep_read(input bit s);
    for (int i = 0; i < N; i++) step(1'b0, s, i, 1'b0, '0);
    step(1'b0, s, 0, 1'b0, '0);
  endtask

  task automatic run(input int cycles);
    for (int i = 0; i < cycles; i++) step(1'b1, 1'b0, 0, 1'b0, '0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_im[i] = '0; m_dm[i] = 1'b0; end
    #35 rst_ni = 1'b1;
    chk_rd = 1'b1;  // R10 reset state checked on early cycles
    step(1'b0, 1'b0, 0, 1'b0, '0);
    chk_rd = 1'b0;
    // fill both regions; reads of never-written cells are not compared
    for (int i = 0; i < N; i++) step(1'b0, 1'b0, i, 1'b1, IW'(((i >> 1) ^ i) & 1));
    for (int i = 0; i < N; i++) step(1'b0, 1'b1, i, 1'b1, enc(0, 0, 0, 0, 0, 0, 15));
    step(1'b0, 1'b0, 0, 1'b0, '0);
    chk_rd = 1'b1;
    req_tag = "R1"; sweep_read(1'b0);
    req_tag = "R2"; sweep_read(1'b1);

    // directed program: memory operands, constants, chaining, halt
    req_tag = "R2";
    step(1'b0, 1'b1, 0, 1'b1, enc(0, 0, 1, 0, 0, 2, 3));
    step(1'b0, 1'b1, 1, 1'b1, enc(1, 1, 9, 1, 0, 9, 0));   // R5 Z=1
    step(1'b0, 1'b1, 2, 1'b1, enc(1, 0, 3, 1, 1, 3, 5));   // R5 Z=0
    step(1'b0, 1'b1, 3, 1'b1, enc(0, 0, 3, 0, 0, 6, 7));
    step(1'b0, 1'b1, 4, 1'b1, enc(0, 0, 0, 0, 0, 0, 15));
    step(1'b0, 1'b1, 4, 1'b0, '0);
    req_tag = "R6"; run(20);
    // R8: external writes during the run must be ignored
    req_tag = "R8";
    step(1'b1, 1'b0, 8, 1'b1, IW'(1));
    step(1'b1, 1'b1, 4, 1'b1, enc(0, 0, 0, 0, 0, 0, 9));
    req_tag = "R7"; run(20);
    req_tag = "R4"; sweep_read(1'b0);
    req_tag = "R8"; sweep_read(1'b1);

    // R9: abort partway, then rerun from address 0
    req_tag = "R9";
    run(12);
    step(1'b0, 1'b0, 0, 1'b0, '0);
    sweep_read(1'b0);
    run(40);
    step(1'b0, 1'b0, 0, 1'b0, '0);
    sweep_read(1'b0);

    // random programs, halt in the last word
    for (int p = 0; p < 4; p++) begin
      req_tag = "R4";
      for (int i = 0; i < N - 1; i++)
        step(1'b0, 1'b1, i, 1'b1,
             enc($urandom % 2, $urandom % 2, $urandom % N, $urandom % 2, $urandom % 2,
                 $urandom % N, $urandom % (N - 1)));
      step(1'b0, 1'b1, N - 1, 1'b1, enc(0, 0, 0, 0, 0, 0, 15));
      req_tag = "R5"; run(6 * N + 10);
      req_tag = "R4"; sweep_read(1'b0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule